// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer that drives a successive-approximation converter core. Software writes one control word that holds a channel select, a length bit, a multi-channel bit and a continuous bit. The block then issues a series of start pulses to the core, each with a channel number, and waits for the core's done pulse before it moves on. Each returned result word lands in a fixed result slot, and the block keeps a completion flag for each slot and a flag for the whole sequence.

The three mode bits sit in the control word as a 3-bit mode number `{scan, multi, len_long}` (scan is the most significant bit, len_long the least). They choose four or eight conversions per sequence, one sequence or an endless repeat, and one fixed channel or an aligned block of channels. Any control write aborts the current work and starts again from slot 0. The core is modelled as a start/done handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all result slots to 0, all slot flags and the sequence flag, deasserts `busy` and produces no `conv_start`.
- R2: The control word is `ctl_data[3:0]` = channel select, `[4]` = len_long, `[5]` = multi, `[6]` = scan. With scan = 0 a sequence has 8 conversions when len_long = 1 and 4 when it is 0. After the last one `busy` falls and no further `conv_start` is issued.
- R3: With multi = 0 every conversion of the sequence uses the channel held in `ctl_data[3:0]`.
- R4: With multi = 1, conversion n uses the block base plus n. The base is the channel select with its low 3 bits cleared (eight conversions) or its low 2 bits cleared (four conversions).
- R5: The result of conversion n is stored in slot n, which `rd_data` shows when `rd_sel` = n. Slots beyond the sequence length keep their values.
- R6: Bit n of `slot_done` sets on the cycle after slot n is written. `seq_done` sets with the flag of the last slot of a sequence, and not before. Neither flag clears except on a control write or reset.
- R7: A control write, even in the middle of a conversion, clears all slot flags and `seq_done`. A done pulse in that same cycle is discarded, and the next `conv_start` comes on the following cycle with the channel for slot 0 of the new word.
- R8: With scan = 1 sequences repeat without a gap in slot order. `seq_done` stays set after the first sequence, and later sequences overwrite the result slots.
- R9: `conv_start` is a one-cycle pulse. The next conversion starts only after a done pulse, and a done pulse while no conversion is pending has no effect on results, flags or starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 7 | Control word: scan, multi, len_long, channel select |
| conv_start | output | 1 | One-cycle start request to the converter core |
| conv_chan | output | 4 | Channel number for the requested conversion |
| conv_done | input | 1 | Core done pulse |
| conv_result | input | 10 | Core result word, valid with conv_done |
| rd_sel | input | 3 | Result slot select |
| rd_data | output | 10 | Selected result slot |
| slot_done | output | 8 | Per-slot completion flags |
| seq_done | output | 1 | Sequence complete flag |
| busy | output | 1 | A sequence is in progress |

## Verification
Directed runs cover each single-shot mode with channel selects whose low bits are nonzero. This shows whether the fixed-channel path and the block-aligned path are kept apart, and whether the alignment follows the sequence length. A random run draws the control word and the core latency (one to three cycles) over many sequences. It finds slot indexing or length errors that a fixed latency would hide. Corner cases include an abort write that lands together with a done pulse, a stray done pulse while idle, and continuous runs carried into a third pass. Together they separate abort handling, the handshake and the sticky sequence flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

   // packed in mode-number order: scan is the MSB, len_long the LSB
   typedef struct packed {
      logic scan;
      logic multi;
      logic len_long;
   } seq_mode_t;

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int CHAN_W    = 4,
   parameter int LONG_LEN  = 8,
   parameter int SHORT_LEN = 4,
   localparam int SLOT_W   = $clog2(LONG_LEN),
   localparam int CTL_W    = CHAN_W + 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_data,
   input  logic              conv_done,
   output logic              start,
   output logic              accept,
   output logic              last,
   output logic              busy,
   output logic [SLOT_W-1:0] slot,
   output seq_mode_t         mode,
   output logic [CHAN_W-1:0] chan_sel
);

   localparam logic [SLOT_W-1:0] LAST_LONG  = SLOT_W'(LONG_LEN - 1);
   localparam logic [SLOT_W-1:0] LAST_SHORT = SLOT_W'(SHORT_LEN - 1);

   seq_state_e        st_q;
   logic [SLOT_W-1:0] slot_q;
   seq_mode_t         mode_q;
   logic [CHAN_W-1:0] chan_q;

   assign last   = (slot_q == (mode_q.len_long ? LAST_LONG : LAST_SHORT));
   assign accept = (st_q == ST_WAIT) && conv_done && !ctl_wr;
   assign start  = (st_q == ST_START);
   assign busy   = (st_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         slot_q <= '0;
         mode_q <= '0;
         chan_q <= '0;
      end else if (ctl_wr) begin
         st_q   <= ST_START;
         slot_q <= '0;
         mode_q <= seq_mode_t'(ctl_data[CHAN_W +: 3]);
         chan_q <= ctl_data[CHAN_W-1:0];
      end else begin
         unique case (st_q)
            ST_START: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (conv_done) begin
                  if (last) begin
                     slot_q <= '0;
                     st_q   <= mode_q.scan ? ST_START : ST_IDLE;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                     st_q   <= ST_START;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign slot     = slot_q;
   assign mode     = mode_q;
   assign chan_sel = chan_q;

endmodule

// File: rtl/adc_seq_chan_map.sv
module adc_seq_chan_map #(
   parameter int CHAN_W    = 4,
   parameter int LONG_LEN  = 8,
   parameter int SHORT_LEN = 4,
   localparam int SLOT_W   = $clog2(LONG_LEN),
   localparam int SHORT_W  = $clog2(SHORT_LEN)
) (
   input  logic [CHAN_W-1:0] chan_sel,
   input  logic [SLOT_W-1:0] slot,
   input  logic              multi,
   input  logic              len_long,
   output logic [CHAN_W-1:0] chan
);

   logic [CHAN_W-1:0] blk_long;
   logic [CHAN_W-1:0] blk_short;

   generate
      if (CHAN_W > SLOT_W) begin : g_long_base
         assign blk_long = {chan_sel[CHAN_W-1:SLOT_W], slot};
      end else begin : g_long_full
         assign blk_long = CHAN_W'(slot);
      end
   endgenerate

   assign blk_short = {chan_sel[CHAN_W-1:SHORT_W], slot[SHORT_W-1:0]};

   always_comb begin
      if (!multi)        chan = chan_sel;
      else if (len_long) chan = blk_long;
      else               chan = blk_short;
   end

endmodule

// File: rtl/adc_seq_result_bank.sv
module adc_seq_result_bank #(
   parameter int RES_W    = 10,
   parameter int SLOTS    = 8,
   localparam int SLOT_W  = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              wr_en,
   input  logic              wr_last,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [RES_W-1:0]  wr_data,
   input  logic [SLOT_W-1:0] rd_sel,
   output logic [RES_W-1:0]  rd_data,
   output logic [SLOTS-1:0]  slot_done,
   output logic              seq_done
);

   logic [SLOTS-1:0][RES_W-1:0] res_all;
   logic                        seq_q;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [RES_W-1:0] val_q;
      logic             flag_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            val_q  <= '0;
            flag_q <= 1'b0;
         end else if (clr) begin
            flag_q <= 1'b0;
         end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
            val_q  <= wr_data;
            flag_q <= 1'b1;
         end
      end
      assign res_all[i]   = val_q;
      assign slot_done[i] = flag_q;
   end

   always_ff @(posedge clk) begin
      if (rst || clr)            seq_q <= 1'b0;
      else if (wr_en && wr_last) seq_q <= 1'b1;
   end

   assign seq_done = seq_q;
   assign rd_data  = res_all[rd_sel];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CHAN_W    = 4,
   parameter int RES_W     = 10,
   parameter int LONG_LEN  = 8,
   parameter int SHORT_LEN = 4,
   localparam int SLOT_W   = $clog2(LONG_LEN),
   localparam int CTL_W    = CHAN_W + 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_data,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   input  logic [SLOT_W-1:0] rd_sel,
   output logic [RES_W-1:0]  rd_data,
   output logic [LONG_LEN-1:0] slot_done,
   output logic              seq_done,
   output logic              busy
);

   generate
      if (LONG_LEN < 2 || (1 << SLOT_W) != LONG_LEN) begin : g_bad_long
         $error("LONG_LEN must be a power of two of at least 2");
      end
      if (SHORT_LEN < 2 || SHORT_LEN >= LONG_LEN
          || (1 << $clog2(SHORT_LEN)) != SHORT_LEN) begin : g_bad_short
         $error("SHORT_LEN must be a power of two, at least 2, below LONG_LEN");
      end
      if (CHAN_W < SLOT_W) begin : g_bad_chan
         $error("CHAN_W must cover a full long channel block");
      end
      if (RES_W < 1) begin : g_bad_res
         $error("RES_W must be positive");
      end
   endgenerate

   logic              accept;
   logic              last;
   logic [SLOT_W-1:0] slot;
   seq_mode_t         mode;
   logic [CHAN_W-1:0] chan_sel;

   adc_seq_fsm #(
      .CHAN_W   (CHAN_W),
      .LONG_LEN (LONG_LEN),
      .SHORT_LEN(SHORT_LEN)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .ctl_wr   (ctl_wr),
      .ctl_data (ctl_data),
      .conv_done(conv_done),
      .start    (conv_start),
      .accept   (accept),
      .last     (last),
      .busy     (busy),
      .slot     (slot),
      .mode     (mode),
      .chan_sel (chan_sel)
   );

   adc_seq_chan_map #(
      .CHAN_W   (CHAN_W),
      .LONG_LEN (LONG_LEN),
      .SHORT_LEN(SHORT_LEN)
   ) u_map (
      .chan_sel(chan_sel),
      .slot    (slot),
      .multi   (mode.multi),
      .len_long(mode.len_long),
      .chan    (conv_chan)
   );

   adc_seq_result_bank #(
      .RES_W(RES_W),
      .SLOTS(LONG_LEN)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .clr      (ctl_wr),
      .wr_en    (accept),
      .wr_last  (last),
      .wr_slot  (slot),
      .wr_data  (conv_result),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data),
      .slot_done(slot_done),
      .seq_done (seq_done)
   );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int CHAN_W    = 4,
   parameter int LONG_LEN  = 8,
   localparam int SLOT_W   = $clog2(LONG_LEN),
   localparam int CTL_W    = CHAN_W + 3
) (
   input logic                clk,
   input logic                rst,
   input logic                ctl_wr,
   input logic [CTL_W-1:0]    ctl_data,
   input logic                conv_start,
   input logic [CHAN_W-1:0]   conv_chan,
   input logic                conv_done,
   input logic [LONG_LEN-1:0] slot_done,
   input logic                seq_done,
   input logic                busy
);

   localparam logic [CHAN_W-1:0] HI_MASK = ~CHAN_W'(LONG_LEN - 1);

   logic [CTL_W-1:0] ctl_q;
   always_ff @(posedge clk) begin
      if (rst)         ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_data;
   end

   a_r9_start_pulse: assert property (@(posedge clk) disable iff (rst)
      conv_start && !ctl_wr |=> !conv_start);

   a_r9_start_cause: assert property (@(posedge clk) disable iff (rst)
      conv_start |-> ($past(ctl_wr) || $past(conv_done)));

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !conv_start);

   a_r7_write_clears: assert property (@(posedge clk) disable iff (rst)
      ctl_wr |=> (slot_done == '0) && !seq_done && conv_start);

   a_r6_seq_sticky: assert property (@(posedge clk) disable iff (rst)
      seq_done && !ctl_wr |=> seq_done);

   a_r6_flags_keep: assert property (@(posedge clk) disable iff (rst)
      !ctl_wr |=> ((slot_done & $past(slot_done)) == $past(slot_done)));

   a_r6_one_new_flag: assert property (@(posedge clk) disable iff (rst)
      !ctl_wr |=> $onehot0(slot_done & ~$past(slot_done)));

   a_r3_fixed_chan: assert property (@(posedge clk) disable iff (rst)
      conv_start && !ctl_q[CHAN_W+1] |-> conv_chan == ctl_q[CHAN_W-1:0]);

   a_r4_block_base: assert property (@(posedge clk) disable iff (rst)
      conv_start && ctl_q[CHAN_W+1]
      |-> ((conv_chan ^ ctl_q[CHAN_W-1:0]) & HI_MASK) == '0);

endmodule

bind adc_seq_ctrl adc_seq_chk #(
   .CHAN_W  (CHAN_W),
   .LONG_LEN(LONG_LEN)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ctl_wr    (ctl_wr),
   .ctl_data  (ctl_data),
   .conv_start(conv_start),
   .conv_chan (conv_chan),
   .conv_done (conv_done),
   .slot_done (slot_done),
   .seq_done  (seq_done),
   .busy      (busy)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ctl_wr = 1'b0;
   logic [6:0] ctl_data = '0;
   logic       conv_start;
   logic [3:0] conv_chan;
   logic       conv_done = 1'b0;
   logic [9:0] conv_result = '0;
   logic [2:0] rd_sel = '0;
   logic [9:0] rd_data;
   logic [7:0] slot_done;
   logic       seq_done;
   logic       busy;

   int n_checks = 0;
   int n_fail   = 0;

   logic [9:0] exp_res [8];
   logic [7:0] exp_flags;
   logic       exp_seq;
   logic [6:0] cur;

   always #10 clk = ~clk;

   adc_seq_ctrl u0 (
      .clk        (clk),
      .rst        (rst),
      .ctl_wr     (ctl_wr),
      .ctl_data   (ctl_data),
      .conv_start (conv_start),
      .conv_chan  (conv_chan),
      .conv_done  (conv_done),
      .conv_result(conv_result),
      .rd_sel     (rd_sel),
      .rd_data    (rd_data),
      .slot_done  (slot_done),
      .seq_done   (seq_done),
      .busy       (busy)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_chan(input logic [6:0] w, input int n);
      if (!w[5]) return w[3:0];
      if (w[4])  return {w[3], 3'(n)};
      return {w[3:2], 2'(n)};
   endfunction

   function automatic int seq_len(input logic [6:0] w);
      return w[4] ? 8 : 4;
   endfunction

   task automatic write_ctl(input logic [6:0] w);
      ctl_data = w;
      ctl_wr   = 1'b1;
      @(negedge clk);
      ctl_wr    = 1'b0;
      exp_flags = '0;
      exp_seq   = 1'b0;
      cur       = w;
   endtask

   task automatic do_conv(input int n);
      logic [9:0] r;
      int lat;
      r   = 10'($urandom());
      lat = $urandom_range(0, 2);
      check("R9 start present", conv_start, 1);
      check(cur[5] ? "R4 block channel" : "R3 fixed channel", conv_chan, exp_chan(cur, n));
      @(negedge clk);
      check("R9 start one cycle", conv_start, 0);
      repeat (lat) @(negedge clk);
      conv_done   = 1'b1;
      conv_result = r;
      @(negedge clk);
      conv_done = 1'b0;
      exp_res[n]   = r;
      exp_flags[n] = 1'b1;
      if (n == seq_len(cur) - 1) exp_seq = 1'b1;
      check("R6 slot flags", slot_done, exp_flags);
      check("R6 sequence flag", seq_done, exp_seq);
   endtask

   task automatic check_results(input string tag);
      for (int i = 0; i < 8; i++) begin
         rd_sel = 3'(i);
         #1;
         check(tag, rd_data, exp_res[i]);
      end
      @(negedge clk);
   endtask

   task automatic run_seq(input int nseq);
      for (int s = 0; s < nseq; s++)
         for (int n = 0; n < seq_len(cur); n++) do_conv(n);
      if (!cur[6]) begin
         check("R2 stops after length", busy, 0);
         check("R2 no further start", conv_start, 0);
         @(negedge clk);
         check("R2 still quiet", conv_start, 0);
         check_results("R5 result slots");
      end
   endtask

   task automatic reset_check();
      for (int i = 0; i < 8; i++) exp_res[i] = '0;
      exp_flags = '0;
      exp_seq   = 1'b0;
      check("R1 busy low", busy, 0);
      check("R1 no start", conv_start, 0);
      check("R1 flags clear", slot_done, 0);
      check("R1 seq flag clear", seq_done, 0);
      check_results("R1 results clear");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      cur = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      reset_check();

      // R2 R3: single-channel modes 0 and 1
      write_ctl(7'b0_0_0_0101); run_seq(1);
      write_ctl(7'b0_0_1_1001); run_seq(1);
      // R4: block modes, low bits of the select ignored
      write_ctl(7'b0_1_0_0110); run_seq(1);
      write_ctl(7'b0_1_1_1101); run_seq(1);
      write_ctl(7'b0_1_0_0011); run_seq(1);
      write_ctl(7'b0_1_1_0111); run_seq(1);

      // R5: a short run leaves slots 4..7 alone
      write_ctl(7'b0_0_0_1111); run_seq(1);

      // R9: stray done while idle is ignored
      conv_done = 1'b1; conv_result = 10'h3FF;
      @(negedge clk);
      conv_done = 1'b0;
      check("R9 stray done no start", conv_start, 0);
      check("R9 stray done flags", slot_done, exp_flags);
      @(negedge clk);
      check("R9 stray done busy", busy, 0);
      check_results("R9 stray done results");

      // R7: abort in the middle, coinciding with a done pulse
      write_ctl(7'b0_0_1_1001);
      for (int n = 0; n < 3; n++) do_conv(n);
      @(negedge clk);
      ctl_data = 7'b0_1_0_0110; ctl_wr = 1'b1;
      conv_done = 1'b1; conv_result = 10'h155;
      @(negedge clk);
      ctl_wr = 1'b0; conv_done = 1'b0;
      exp_flags = '0; exp_seq = 1'b0; cur = 7'b0_1_0_0110;
      check("R7 flags cleared", slot_done, 0);
      check("R7 seq flag cleared", seq_done, 0);
      check("R7 restart channel", conv_chan, exp_chan(cur, 0));
      run_seq(1);

      // R8: continuous block of four, into a third pass
      write_ctl(7'b1_1_0_0101);
      run_seq(2);
      check("R8 seq flag after passes", seq_done, 1);
      check("R8 wraps to slot 0", conv_chan, exp_chan(cur, 0));
      do_conv(0); do_conv(1);
      check("R8 seq flag stays", seq_done, 1);
      // R8: continuous single channel, eight long
      write_ctl(7'b1_0_1_0010);
      run_seq(1);
      do_conv(0);
      check("R8 single chan still running", busy, 1);
      write_ctl(7'b0_0_0_0001); run_seq(1);

      // random single-shot runs
      for (int k = 0; k < 24; k++) begin
         write_ctl(7'($urandom()) & 7'h3F);
         run_seq(1);
      end

      // R1: reset after activity
      write_ctl(7'b0_0_1_0100);
      do_conv(0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      reset_check();

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule